// File: doc/BRIEF.md
# Tag-Steered Five-Port Mesh Router with Neighbour FIFO Borrowing

This block is one router of a two-dimensional mesh. It has four neighbour ports (north, east, south, west) and one local port for the attached processing element. Each input port has a small FIFO. Every flit carries its own steering information: a local bit and a two-bit direction tag. These pick one of five outputs, so the crossbar needs no route computation. Flits from different inputs that are headed for different outputs move in the same cycle. Each output has a round-robin arbiter that shares it among the FIFO heads that want it.

Both edges use a handshake. A sender holds a flit on an input until the router raises that port's write acknowledge. A receiver takes a flit from an output by raising its ready line while the output is valid. When an input's own FIFO is full, the input asks the FIFO of the next port in ring order for room. It writes there only if that request is granted. A borrowed flit keeps its tag, so it still leaves on the output it asked for.

A flit is `PW+3` bits wide. Bit `PW+2` is the local bit. Bits `PW+1:PW` are the tag. Bits `PW-1:0` are the payload.

Top module: `mesh_rtr`

## Requirements
- R1: A flit with local bit 1 leaves on output 4 (local), whatever its tag. A flit with local bit 0 leaves on the output its tag names: 00 north (0), 01 east (1), 10 south (2), 11 west (3). The flit leaves unchanged, one cycle after it is accepted if the path is free.
- R2: When an input is valid and its own FIFO has a free entry, that port's write acknowledge is high in the same cycle. The flit is stored at the next clock edge.
- R3: When an input is valid, its own FIFO is full and no borrow is granted, its write acknowledge stays low. The router stores nothing from that port, and the sender keeps the flit.
- R4: When input i is valid and its own FIFO is full, it requests space in the FIFO of input (i+1) mod 5. If that FIFO has at least two free entries, the request is granted: the acknowledge rises, the flit is stored there, and it later leaves on the output named by its own tag.
- R5: A borrow request is refused while the target FIFO has fewer than two free entries.
- R6: An output transfers a flit exactly in a cycle where its valid and ready are both high. Every accepted flit leaves exactly once, and an output with nothing for it holds valid low.
- R7: Flits from different FIFOs that name different outputs are presented on those outputs in the same cycle.
- R8: Inputs that contend for one output are served in rotating order. The arbiter pointer moves only after a completed transfer, so while ready is low the chosen flit stays on the output.
- R9: After reset all FIFOs are empty and every output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 5 | Per-input flit valid (index 0 N, 1 E, 2 S, 3 W, 4 local) |
| inData | input | 5*(PW+3) | Per-input flit; port i occupies bits i*(PW+3) upward |
| inAck | output | 5 | Per-input write acknowledge; the flit is taken at the edge that ends a cycle with valid and acknowledge both high |
| outValid | output | 5 | Per-output flit valid |
| outData | output | 5*(PW+3) | Per-output flit, sliced like inData |
| outReady | input | 5 | Per-output read acknowledge from the receiver |

## Verification
The assertions assume that the flit on an input stays the same while its valid is high and its acknowledge is low. The stimulus meets this because every flit is driven just after a clock edge and held until it is acknowledged or the attempt is dropped. They also assume that ready lines change only between clock edges, and that reset is applied before any traffic. The bench drives random ready patterns and bursts on all five inputs. These bursts fill FIFOs and trigger borrowing. All flits stay in legal formats, because every tag and local-bit combination names a real output.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NPORT = 5;
  localparam int SELW = 3;
  localparam int P_N = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_W = 3;
  localparam int P_L = 4;

  typedef struct packed {
    logic [NPORT-1:0] wrOwn;
    logic [NPORT-1:0] wrBorrow;
    logic [NPORT-1:0] pop;
    logic [NPORT-1:0] outVld;
    logic [NPORT-1:0][SELW-1:0] outSel;
  } strobe_t;

  function automatic logic [SELW-1:0] routeOf(input logic lcl, input logic [1:0] tag);
    return lcl ? SELW'(P_L) : {1'b0, tag};
  endfunction
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int W = 11,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrA,
  input  logic [W-1:0]  dA,
  input  logic          wrB,
  input  logic [W-1:0]  dB,
  input  logic          pop,
  output logic          headValid,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] free
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [AW-1:0] wrPtrB;

  assign wrPtrB = wrPtr + AW'(wrA);

  always_ff @(posedge clk) begin
    if (wrA) mem[wrPtr] <= dA;
    if (wrB) mem[wrPtrB] <= dB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(wrA) + AW'(wrB);
      rdPtr <= rdPtr + AW'(pop);
      count <= count + CW'(wrA) + CW'(wrB) - CW'(pop);
    end
  end

  assign headValid = (count != '0);
  assign headData  = mem[rdPtr];
  assign free      = CW'(DEPTH) - count;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (CW'(wrA) + CW'(wrB)) <= free);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> headValid);
  p_borrow_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrB |-> free >= CW'(2));
endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] winner;

  always_comb begin
    logic found;
    int idx;
    gnt = '0;
    winner = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        winner = IW'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (adv) ptr <= (int'(winner) == N - 1) ? '0 : winner + 1'b1;
  end

  p_onehot_gnt_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));
  p_hold_winner_r8: assert property (@(posedge clk) disable iff (!rstN)
    !adv |=> ($stable(req) -> $stable(gnt)));
endmodule

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
  import rtr_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NPORT-1:0]           inValid,
  input  logic [NPORT-1:0]           headValid,
  input  logic [NPORT-1:0][SELW-1:0] headRoute,
  input  logic [NPORT-1:0][CW-1:0]   free,
  input  logic [NPORT-1:0]           outReady,
  output strobe_t                    st,
  output logic [NPORT-1:0]           inAck
);
  logic [NPORT-1:0][NPORT-1:0] req;
  logic [NPORT-1:0][NPORT-1:0] gnt;
  logic [NPORT-1:0] borrowGnt;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    for (genvar f = 0; f < NPORT; f++) begin : g_req
      assign req[o][f] = headValid[f] && (headRoute[f] == SELW'(o));
    end
    rtr_rr_arb #(.N(NPORT)) arb_i (
      .clk (clk),
      .rstN(rstN),
      .req (req[o]),
      .adv ((|gnt[o]) && outReady[o]),
      .gnt (gnt[o])
    );
  end

  always_comb begin
    int t;
    st = '0;
    borrowGnt = '0;
    for (int i = 0; i < NPORT; i++) begin
      t = (i + 1) % NPORT;
      st.wrOwn[i] = inValid[i] && (free[i] != '0);
      borrowGnt[i] = inValid[i] && (free[i] == '0) && (free[t] >= CW'(2));
      st.wrBorrow[t] = borrowGnt[i];
      inAck[i] = st.wrOwn[i] || borrowGnt[i];
    end
    for (int o = 0; o < NPORT; o++) begin
      st.outVld[o] = |gnt[o];
      for (int f = 0; f < NPORT; f++) begin
        if (gnt[o][f]) st.outSel[o] = SELW'(f);
        st.pop[f] = st.pop[f] | (gnt[o][f] & outReady[o]);
      end
    end
  end
endmodule

// File: rtl/rtr_dp.sv
module rtr_dp
  import rtr_pkg::*;
#(
  parameter int PW = 8,
  parameter int DEPTH = 4,
  localparam int FW = PW + 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic [NPORT*FW-1:0]        inData,
  output logic [NPORT-1:0]           headValid,
  output logic [NPORT-1:0][SELW-1:0] headRoute,
  output logic [NPORT-1:0][CW-1:0]   free,
  output logic [NPORT-1:0]           outValid,
  output logic [NPORT*FW-1:0]        outData
);
  logic [NPORT-1:0][FW-1:0] headData;

  for (genvar i = 0; i < NPORT; i++) begin : g_fifo
    localparam int PREV = (i + NPORT - 1) % NPORT;
    rtr_fifo #(.W(FW), .DEPTH(DEPTH)) fifo_i (
      .clk      (clk),
      .rstN     (rstN),
      .wrA      (st.wrOwn[i]),
      .dA       (inData[i*FW +: FW]),
      .wrB      (st.wrBorrow[i]),
      .dB       (inData[PREV*FW +: FW]),
      .pop      (st.pop[i]),
      .headValid(headValid[i]),
      .headData (headData[i]),
      .free     (free[i])
    );
    assign headRoute[i] = routeOf(headData[i][FW-1], headData[i][FW-2:FW-3]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_xbar
    assign outData[o*FW +: FW] = headData[st.outSel[o]];
    p_route_match_r1: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] |-> routeOf(outData[o*FW+FW-1], outData[o*FW+FW-2 -: 2]) == SELW'(o));
  end

  assign outValid = st.outVld;
endmodule

// File: rtl/mesh_rtr.sv
module mesh_rtr
  import rtr_pkg::*;
#(
  parameter int PW = 8,
  parameter int DEPTH = 4,
  localparam int FW = PW + 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          inValid,
  input  logic [5*FW-1:0]     inData,
  output logic [4:0]          inAck,
  output logic [4:0]          outValid,
  output logic [5*FW-1:0]     outData,
  input  logic [4:0]          outReady
);
  strobe_t st;
  logic [NPORT-1:0] headValid;
  logic [NPORT-1:0][SELW-1:0] headRoute;
  logic [NPORT-1:0][CW-1:0] free;

  rtr_ctrl #(.CW(CW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .headValid(headValid),
    .headRoute(headRoute),
    .free     (free),
    .outReady (outReady),
    .st       (st),
    .inAck    (inAck)
  );

  rtr_dp #(.PW(PW), .DEPTH(DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .inData   (inData),
    .headValid(headValid),
    .headRoute(headRoute),
    .free     (free),
    .outValid (outValid),
    .outData  (outData)
  );

  p_full_no_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid[0] && free[0] == '0 && free[1] < CW'(2)) |-> !inAck[0]);
endmodule

// File: tb/mesh_rtr_tb_top.sv
`timescale 1ns/1ps
module mesh_rtr_tb_top;
  localparam int PW = 8;
  localparam int DEPTH = 4;
  localparam int FW = PW + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] inValid = '0;
  logic [5*FW-1:0] inData = '0;
  logic [4:0] inAck;
  logic [4:0] outValid;
  logic [5*FW-1:0] outData;
  logic [4:0] outReady = '0;

  int total = 0;
  int bad = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;

  typedef struct { int port; logic [FW-1:0] flit; } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  mesh_rtr #(.PW(PW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inAck(inAck), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  function automatic logic [FW-1:0] mk(input logic lcl, input logic [1:0] tag, input logic [PW-1:0] pl);
    return {lcl, tag, pl};
  endfunction

  function automatic int dest(input logic [FW-1:0] f);
    return f[FW-1] ? 4 : int'(f[FW-2:FW-3]);
  endfunction

  function automatic logic [FW-1:0] outSlice(input int o);
    return outData[o*FW +: FW];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int p, input logic [FW-1:0] f, input int maxWait, output bit acc);
    @(posedge clk); #1;
    inValid[p] = 1'b1;
    inData[p*FW +: FW] = f;
    acc = 1'b0;
    for (int w = 0; w < maxWait; w++) begin
      @(negedge clk);
      if (inAck[p]) begin
        expQ.push_back('{port: dest(f), flit: f});
        acc = 1'b1;
        break;
      end
    end
    @(posedge clk); #1;
    inValid[p] = 1'b0;
  endtask

  // monitor: every completed output transfer must match an expected flit (R6, R1, R4)
  always @(negedge clk) begin
    if (rstN && monOn) begin
      for (int o = 0; o < 5; o++) begin
        if (outValid[o] && outReady[o]) begin
          int hit = -1;
          foreach (expQ[k]) if (hit < 0 && expQ[k].port == o && expQ[k].flit == outSlice(o)) hit = k;
          chk(hit >= 0, "R6", "unexpected flit on output", 32'(outSlice(o)), 32'(o));
          if (hit >= 0) expQ.delete(hit);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "R6", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [FW-1:0] held;
    logic [PW-1:0] seq [4];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(outValid == 5'b0, "R9", "outValid after reset", 32'(outValid), 0);
    chk(inAck == 5'b0, "R9", "inAck after reset", 32'(inAck), 0);
    monOn = 1'b1;

    // R1 / R2: each destination once, output held to see it appear
    for (int d = 0; d < 5; d++) begin
      logic [FW-1:0] f;
      f = (d == 4) ? mk(1'b1, 2'(d), 8'(8'h40 + d)) : mk(1'b0, 2'(d), 8'(8'h40 + d));
      send((d + 2) % 5, f, 4, acc);
      chk(acc, "R2", "write ack on free FIFO", 32'(acc), 1);
      @(negedge clk);
      chk(outValid == 5'(1 << d), "R1", "output valid vector", 32'(outValid), 32'(1 << d));
      chk(outSlice(d) == f, "R1", "flit on output", 32'(outSlice(d)), 32'(f));
      @(posedge clk); #1 outReady = '1;
      repeat (2) @(posedge clk);
      #1 outReady = '0;
    end

    // R7: four inputs to four different outputs at once
    fork
      begin bit a; send(0, mk(0, 2'd1, 8'h50), 4, a); end
      begin bit a; send(1, mk(0, 2'd2, 8'h51), 4, a); end
      begin bit a; send(2, mk(0, 2'd3, 8'h52), 4, a); end
      begin bit a; send(3, mk(0, 2'd0, 8'h53), 4, a); end
    join
    @(negedge clk);
    chk(outValid == 5'b01111, "R7", "concurrent outputs", 32'(outValid), 32'h0f);
    @(posedge clk); #1 outReady = '1;
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 5'b0, "R6", "no duplicate after transfer", 32'(outValid), 0);
    @(posedge clk); #1 outReady = '0;

    // R8: two inputs contend for south
    fork
      begin bit a; send(0, mk(0, 2'd2, 8'h01), 4, a); send(0, mk(0, 2'd2, 8'h02), 4, a); end
      begin bit a; send(1, mk(0, 2'd2, 8'h11), 4, a); send(1, mk(0, 2'd2, 8'h12), 4, a); end
    join
    @(negedge clk);
    held = outSlice(2);
    repeat (2) begin
      @(negedge clk);
      chk(outValid[2] && outSlice(2) == held, "R8", "winner held while not ready", 32'(outSlice(2)), 32'(held));
    end
    @(posedge clk); #1 outReady[2] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(outValid[2], "R8", "south valid during drain", 32'(outValid[2]), 1);
      seq[k] = outSlice(2)[PW-1:0];
    end
    chk(seq[0] == held[PW-1:0], "R8", "first served is held winner", 32'(seq[0]), 32'(held[PW-1:0]));
    for (int k = 1; k < 4; k++)
      chk(seq[k][7:4] != seq[k-1][7:4], "R8", "sources alternate", 32'(seq[k]), 32'(seq[k-1]));
    @(posedge clk); #1 outReady = '0;
    repeat (2) @(posedge clk);

    // R3 / R4 / R5: fill FIFO 0, borrow into FIFO 1, then refuse
    for (int k = 0; k < DEPTH; k++) begin
      send(0, mk(0, 2'd3, 8'(8'h60 + k)), 4, acc);
      chk(acc, "R2", "fill own FIFO", 32'(acc), 1);
    end
    send(0, mk(0, 2'd1, 8'h6a), 4, acc);
    chk(acc, "R4", "borrow granted with room", 32'(acc), 1);
    for (int k = 0; k < 2; k++) begin
      send(1, mk(0, 2'd0, 8'(8'h70 + k)), 4, acc);
      chk(acc, "R2", "own write into FIFO 1", 32'(acc), 1);
    end
    send(0, mk(0, 2'd2, 8'h6f), 6, acc);
    chk(!acc, "R3", "full and no borrow keeps ack low", 32'(acc), 0);
    chk(!acc, "R5", "borrow refused with one free entry", 32'(acc), 0);
    @(posedge clk); #1 outReady = '1;
    repeat (20) @(posedge clk);
    chk(expQ.size() == 0, "R4", "borrowed flit delivered on its tag output", 32'(expQ.size()), 0);
    send(0, mk(0, 2'd2, 8'h6f), 4, acc);
    chk(acc, "R2", "accepted after drain", 32'(acc), 1);
    repeat (4) @(posedge clk);

    // random traffic on all ports with random back-pressure
    fork
      begin
        for (int c = 0; c < 3000; c++) begin
          @(posedge clk); #1 outReady = 5'($urandom);
        end
        outReady = '1;
      end
      for (int p = 0; p < 5; p++) begin
        fork
          automatic int pp = p;
          begin
            bit a;
            for (int n = 0; n < 120; n++) begin
              repeat ($urandom % 3) @(posedge clk);
              send(pp, mk(1'($urandom), 2'($urandom), 8'((pp << 5) + n)), 200, a);
            end
          end
        join_none
      end
    join
    wait fork;
    #1 outReady = '1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, "R6", "every accepted flit delivered", 32'(expQ.size()), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule